// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a 32-bit in-order processor core that runs a six-instruction integer subset through five clocked stages: fetch, decode, execute, memory access and writeback. A register bank sits between each pair of stages. Once the pipeline is full it retires one instruction per clock. It drives a synchronous, word-organised instruction memory and a synchronous data memory. Both are addressed with byte addresses whose low two bits are zero. Read data returns one clock after the address. A combinational debug port reads the register file.

The core has no forwarding and no interlocks. A program must place enough independent instructions or NOPs between a producer and its consumer that the producer reaches writeback while the consumer is still in decode. Writeback writes the register file, and a decode-stage read of the same register in that cycle sees the new value, so two NOPs between dependent instructions are enough. Jumps and taken branches are resolved in execute, and the two younger instructions already fetched are discarded.

Top module: `pipe5_core`

## Requirements
- R1: While reset is asserted, imem_addr equals the RESET_PC parameter, dmem_we is low and every register reads zero on the debug port.
- R2: With no redirect, the fetch address advances by 4 every clock.
- R3: Register add (opcode bits [31:26]=000000, funct bits [5:0]=100000, shift bits [10:6]=0, rs in [25:21], rt in [20:16], rd in [15:11]) writes rs+rt to rd.
- R4: Add-immediate (opcode 001000) writes rs plus the immediate in bits [15:0], sign-extended to 32 bits, to rt.
- R5: Load word (opcode 100011) reads data memory at rs plus the sign-extended immediate during the memory stage and writes the returned word to rt in writeback.
- R6: Store word (opcode 101011) raises dmem_we for one clock with dmem_addr equal to rs plus the sign-extended immediate and dmem_wdata equal to rt.
- R7: Jump (opcode 000010) makes the fetch address, three clocks after the jump was fetched, equal to bits [31:28] of the jump's own address, then its 26-bit field in [25:0], then two zero bits.
- R8: Branch-if-zero (opcode 000100 with rt=0) redirects fetch to its address+4 plus the sign-extended immediate shifted left by two when rs reads zero, and falls through sequentially otherwise.
- R9: After a jump or taken branch, the two instructions fetched behind it write no register and no memory.
- R10: Register 0 always reads zero, and writes addressed to it are dropped.
- R11: A value written in writeback is seen by an instruction reading that register in decode in the same clock, so two NOPs between dependent instructions suffice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word, valid one clock after its address |
| dmem_addr | output | 32 | Byte address for a load or store in the memory stage |
| dmem_we | output | 1 | Write strobe for a store |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data, valid one clock after its address |
| dbg_idx | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the register selected by dbg_idx |

## Verification
The in-RTL assertions check the following on every clock: fetch advances by four unless a redirect is pending, a redirect leaves both younger stage slots empty, a jump keeps the region bits of its own address, a store strobe only follows a store in execute, and a register-file write lands in the addressed entry. Whether each instruction computes the right architectural value can only be seen in the bench scenarios. These cover negative immediates, loads of stored data, forward and backward branches, the squashed slots behind redirects and writes aimed at register 0. The bench compares the fetch address every clock, compares each store as it happens, and compares the full register file at the end against a behavioural instruction-level model.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
    localparam int XLEN = 32;
    localparam int RIDX = 5;
    localparam int IMMW = 16;
    localparam int TGTW = 26;
    localparam int OPCW = 6;

    localparam logic [OPCW-1:0] OPC_REG  = 6'b000000;
    localparam logic [OPCW-1:0] OPC_ADDI = 6'b001000;
    localparam logic [OPCW-1:0] OPC_LW   = 6'b100011;
    localparam logic [OPCW-1:0] OPC_SW   = 6'b101011;
    localparam logic [OPCW-1:0] OPC_J    = 6'b000010;
    localparam logic [OPCW-1:0] OPC_BZ   = 6'b000100;
    localparam logic [5:0]      FN_ADD   = 6'b100000;

    typedef enum logic [2:0] {
        OP_NOP, OP_ADD, OP_ADDI, OP_LW, OP_SW, OP_J, OP_BZ
    } op_e;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc;
    } fd_t;

    typedef struct packed {
        logic            valid;
        op_e             op;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] imm;
        logic [RIDX-1:0] dst;
        logic [TGTW-1:0] tgt;
    } dx_t;

    typedef struct packed {
        logic            wr;
        logic            ld;
        logic            st;
        logic [XLEN-1:0] res;
        logic [XLEN-1:0] sdata;
        logic [RIDX-1:0] dst;
    } xm_t;

    typedef struct packed {
        logic            wr;
        logic            ld;
        logic [XLEN-1:0] res;
        logic [RIDX-1:0] dst;
    } mw_t;
endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output op_e             op,
    output logic [RIDX-1:0] rs,
    output logic [RIDX-1:0] rt,
    output logic [RIDX-1:0] dst,
    output logic [XLEN-1:0] imm,
    output logic [TGTW-1:0] tgt
);
    logic [OPCW-1:0] opc;
    logic [RIDX-1:0] rd;

    always_comb begin
        opc = instr[XLEN-1 -: OPCW];
        rs  = instr[25:21];
        rt  = instr[20:16];
        rd  = instr[15:11];
        imm = {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
        tgt = instr[TGTW-1:0];
        op  = OP_NOP;
        dst = rt;
        case (opc)
            OPC_REG: begin
                if (instr[5:0] == FN_ADD && instr[10:6] == '0) begin
                    op  = OP_ADD;
                    dst = rd;
                end
            end
            OPC_ADDI: op = OP_ADDI;
            OPC_LW:   op = OP_LW;
            OPC_SW:   op = OP_SW;
            OPC_J:    op = OP_J;
            OPC_BZ:   if (rt == '0) op = OP_BZ;
            default:  op = OP_NOP;
        endcase
    end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
    import pipe5_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RIDX-1:0] ra_idx,
    output logic [XLEN-1:0] ra_data,
    input  logic [RIDX-1:0] rb_idx,
    output logic [XLEN-1:0] rb_data,
    input  logic [RIDX-1:0] dbg_idx,
    output logic [XLEN-1:0] dbg_data,
    input  logic            we,
    input  logic [RIDX-1:0] wa,
    input  logic [XLEN-1:0] wd
);
    localparam int NREG = 1 << RIDX;

    logic [XLEN-1:0] regs_q [NREG];
    logic [XLEN-1:0] regs_d [NREG];

    function automatic logic [XLEN-1:0] rd_port(input logic [RIDX-1:0] idx);
        if (idx == '0)
            return '0;
        else if (we && wa == idx)
            return wd;
        else
            return regs_q[idx];
    endfunction

    always_comb begin
        regs_d = regs_q;
        if (we && wa != '0)
            regs_d[wa] = wd;
        ra_data  = rd_port(ra_idx);
        rb_data  = rd_port(rb_idx);
        dbg_data = (dbg_idx == '0) ? '0 : regs_q[dbg_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // R11
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> regs_q[$past(wa)] == $past(wd));
endmodule

// File: rtl/pipe5_exec.sv
module pipe5_exec
    import pipe5_pkg::*;
(
    input  dx_t             dx,
    output xm_t             xm,
    output logic            redirect,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] opnd;

    always_comb begin
        pc4      = dx.pc + XLEN'(4);
        opnd     = (dx.op == OP_ADD) ? dx.b : dx.imm;
        redirect = 1'b0;
        target   = pc4 + {dx.imm[XLEN-3:0], 2'b00};
        if (dx.valid && dx.op == OP_J) begin
            redirect = 1'b1;
            target   = {dx.pc[XLEN-1 -: 4], dx.tgt, 2'b00};
        end else if (dx.valid && dx.op == OP_BZ && dx.a == '0) begin
            redirect = 1'b1;
        end
        xm.wr    = dx.valid && (dx.op == OP_ADD || dx.op == OP_ADDI || dx.op == OP_LW);
        xm.ld    = dx.valid && dx.op == OP_LW;
        xm.st    = dx.valid && dx.op == OP_SW;
        xm.res   = dx.a + opnd;
        xm.sdata = dx.b;
        xm.dst   = dx.dst;
    end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic        dmem_we,
    output logic [31:0] dmem_wdata,
    input  logic [31:0] dmem_rdata,
    input  logic [4:0]  dbg_idx,
    output logic [31:0] dbg_data
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
        fd_t             fd;
        dx_t             dx;
        xm_t             xm;
        mw_t             mw;
    } pipe_t;

    pipe_t st_d, st_q;

    op_e             dec_op;
    logic [RIDX-1:0] dec_rs, dec_rt, dec_dst;
    logic [XLEN-1:0] dec_imm;
    logic [TGTW-1:0] dec_tgt;
    logic [XLEN-1:0] rf_a, rf_b, wb_data;
    xm_t             ex_xm;
    logic            redirect;
    logic [XLEN-1:0] target;

    pipe5_decode u_dec (
        .instr (imem_rdata),
        .op    (dec_op),
        .rs    (dec_rs),
        .rt    (dec_rt),
        .dst   (dec_dst),
        .imm   (dec_imm),
        .tgt   (dec_tgt)
    );

    assign wb_data = st_q.mw.ld ? dmem_rdata : st_q.mw.res;

    pipe5_regfile u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (dec_rs),
        .ra_data  (rf_a),
        .rb_idx   (dec_rt),
        .rb_data  (rf_b),
        .dbg_idx  (dbg_idx),
        .dbg_data (dbg_data),
        .we       (st_q.mw.wr),
        .wa       (st_q.mw.dst),
        .wd       (wb_data)
    );

    pipe5_exec u_ex (
        .dx       (st_q.dx),
        .xm       (ex_xm),
        .redirect (redirect),
        .target   (target)
    );

    always_comb begin
        st_d = st_q;
        // fetch
        st_d.pc       = redirect ? target : st_q.pc + XLEN'(4);
        st_d.fd.valid = !redirect;
        st_d.fd.pc    = st_q.pc;
        // decode
        st_d.dx.valid = st_q.fd.valid && !redirect && dec_op != OP_NOP;
        st_d.dx.op    = dec_op;
        st_d.dx.pc    = st_q.fd.pc;
        st_d.dx.a     = rf_a;
        st_d.dx.b     = rf_b;
        st_d.dx.imm   = dec_imm;
        st_d.dx.dst   = dec_dst;
        st_d.dx.tgt   = dec_tgt;
        // execute
        st_d.xm       = ex_xm;
        // memory
        st_d.mw.wr    = st_q.xm.wr;
        st_d.mw.ld    = st_q.xm.ld;
        st_d.mw.res   = st_q.xm.res;
        st_d.mw.dst   = st_q.xm.dst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr  = st_q.pc;
    assign dmem_addr  = st_q.xm.res;
    assign dmem_we    = st_q.xm.st;
    assign dmem_wdata = st_q.xm.sdata;

    // R2
    fetch_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> st_q.pc == $past(st_q.pc) + XLEN'(4));

    // R9
    squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (!st_q.fd.valid && !st_q.dx.valid));

    // R7
    jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dx.valid && st_q.dx.op == OP_J) |=> st_q.pc[XLEN-1 -: 4] == $past(st_q.dx.pc[XLEN-1 -: 4]));

    // R6
    store_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> $past(st_q.dx.valid && st_q.dx.op == OP_SW));
endmodule

// File: tb/pipe5_core_tb.sv
`timescale 1ns/1ps
module pipe5_core_tb;
    localparam logic [31:0] BASE = 32'h9000_0000;
    localparam int RUN_CYCLES = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, dbg_data;
    logic        dmem_we;
    logic [4:0]  dbg_idx = '0;

    logic [31:0] prog   [256];
    logic [31:0] dmem   [256];
    logic [31:0] rmem   [256];
    logic [31:0] rreg   [32];
    logic [31:0] exp_fetch[$];
    string       exp_ftag[$];
    logic [31:0] exp_sa[$];
    logic [31:0] exp_sd[$];
    int          wp = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pipe5_core #(.RESET_PC(BASE)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dbg_idx    (dbg_idx),
        .dbg_data   (dbg_data)
    );

    always @(posedge clk) begin
        imem_rdata <= prog[imem_addr[9:2]];
        if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
        dmem_rdata <= dmem[dmem_addr[9:2]];
    end

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] f_add(int rs, int rt, int rd);
        return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, 6'b100000};
    endfunction
    function automatic logic [31:0] f_imm(logic [5:0] opc, int rs, int rt, int imm);
        return {opc, rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] f_jmp(logic [31:0] t);
        return {6'b000010, t[27:2]};
    endfunction

    task automatic put(input logic [31:0] w);
        prog[wp] = w;
        wp++;
    endtask
    task automatic emit(input logic [31:0] w);
        put(w); put(32'h0); put(32'h0);
    endtask

    function automatic string reg_tag(int i);
        case (i)
            0: return "R10";
            2: return "R4";
            3: return "R3";
            6: return "R5";
            11, 12, 13, 20, 21: return "R9";
            16: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic build_prog();
        int loop_at, bz_at, jt;
        for (int i = 0; i < 256; i++) begin prog[i] = '0; dmem[i] = '0; rmem[i] = '0; end
        emit(f_imm(6'b001000, 0, 1, 5));          // R4 r1 = 5
        emit(f_imm(6'b001000, 0, 2, -3));         // R4 negative immediate
        emit(f_add(1, 2, 3));                     // R3 r3 = 2
        emit(f_imm(6'b001000, 0, 0, 9));          // R10 write to r0
        emit(f_add(0, 1, 4));                     // R10 r0 reads zero
        emit(f_imm(6'b001000, 0, 5, 32'h40));
        emit(f_imm(6'b101011, 5, 3, 8));          // R6 store to 0x48
        emit(f_imm(6'b101011, 5, 2, -4));         // R6 store to 0x3C
        emit(f_imm(6'b100011, 5, 6, 8));          // R5 load back
        emit(f_add(6, 6, 7));                     // R11
        emit(f_imm(6'b000100, 1, 0, 40));         // R8 not taken
        emit(f_imm(6'b001000, 0, 8, 1));
        put(f_imm(6'b000100, 0, 0, 3));           // R8 forward taken
        put(f_imm(6'b001000, 0, 11, 11));         // R9 squashed
        put(f_imm(6'b001000, 0, 12, 12));         // R9 squashed
        put(f_imm(6'b001000, 0, 13, 13));         // skipped
        emit(f_imm(6'b001000, 0, 14, 14));
        loop_at = wp;
        emit(f_imm(6'b001000, 16, 16, 1));
        emit(f_add(17, 0, 19));
        emit(f_imm(6'b001000, 0, 17, 1));
        bz_at = wp;
        emit(f_imm(6'b000100, 19, 0, loop_at - (bz_at + 1))); // R8 backward
        jt = 200;
        put(f_jmp(BASE + 32'(jt * 4)));           // R7
        put(f_imm(6'b001000, 0, 20, 20));         // R9 squashed
        put(f_imm(6'b001000, 0, 21, 21));         // R9 squashed
        wp = jt;
        emit(f_imm(6'b001000, 0, 22, 22));
        put(f_jmp(BASE + 32'(wp * 4)));           // halt loop
    endtask

    task automatic run_model();
        logic [31:0] pc, w, sx, ea, tgt;
        string why, ttag;
        bit taken;
        int rs, rt, rd;
        for (int i = 0; i < 32; i++) rreg[i] = '0;
        pc = BASE;
        why = "R2";
        while (exp_fetch.size() < RUN_CYCLES + 8) begin
            w = prog[pc[9:2]];
            exp_fetch.push_back(pc);
            exp_ftag.push_back(why);
            rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
            sx = {{16{w[15]}}, w[15:0]};
            ea = rreg[rs] + sx;
            taken = 1'b0;
            tgt = '0;
            ttag = "R2";
            case (w[31:26])
                6'b000000: if (w[5:0] == 6'b100000 && w[10:6] == 5'd0 && rd != 0) rreg[rd] = rreg[rs] + rreg[rt];
                6'b001000: if (rt != 0) rreg[rt] = ea;
                6'b100011: if (rt != 0) rreg[rt] = rmem[ea[9:2]];
                6'b101011: begin rmem[ea[9:2]] = rreg[rt]; exp_sa.push_back(ea); exp_sd.push_back(rreg[rt]); end
                6'b000010: begin taken = 1'b1; tgt = {pc[31:28], w[25:0], 2'b00}; ttag = "R7"; end
                6'b000100: if (rt == 0 && rreg[rs] == 0) begin
                    taken = 1'b1; tgt = pc + 4 + (sx << 2); ttag = "R8";
                end
                default: ;
            endcase
            if (taken) begin
                exp_fetch.push_back(pc + 4); exp_ftag.push_back("R9");
                exp_fetch.push_back(pc + 8); exp_ftag.push_back("R9");
                pc = tgt;
                why = ttag;
            end else begin
                pc = pc + 4;
                why = "R2";
            end
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        build_prog();
        run_model();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "imem_addr in reset", imem_addr, BASE);
        check("R1", "dmem_we in reset", {31'b0, dmem_we}, 32'h0);
        for (int i = 0; i < 32; i++) begin
            dbg_idx = 5'(i);
            #0.1;
            check("R1", $sformatf("reg %0d in reset", i), dbg_data, 32'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        for (int c = 0; c < RUN_CYCLES; c++) begin
            check(exp_ftag[0], $sformatf("fetch addr cycle %0d", c), imem_addr, exp_fetch[0]);
            void'(exp_fetch.pop_front());
            void'(exp_ftag.pop_front());
            if (dmem_we) begin
                if (exp_sa.size() == 0) begin
                    check("R6", "unexpected store addr", dmem_addr, 32'hxxxx_xxxx);
                end else begin
                    check("R6", "store addr", dmem_addr, exp_sa.pop_front());
                    check("R6", "store data", dmem_wdata, exp_sd.pop_front());
                end
            end
            @(negedge clk);
            #0.5;
        end
        check("R6", "stores left unissued", 32'(exp_sa.size()), 32'h0);
        for (int i = 0; i < 32; i++) begin
            dbg_idx = 5'(i);
            #0.1;
            check(reg_tag(i), $sformatf("final reg %0d", i), dbg_data, rreg[i]);
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule